// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the serial side of a 32K x 8 byte memory that needs no write delay. A system clock oversamples the SPI pins (SCK, active-low chip select, serial data in and an active-low pause input), and the block runs exactly one command for each select-low window. It turns the serial traffic into single-byte read and write strobes on a synchronous RAM port. A 15-bit address register loads from the command header and advances after every byte. Read data and status bytes go back out on SO, with a separate output-enable that stands in for the pad tri-state.

The command set covers these operations: set and clear the write-enable latch, read and write the status byte, stream data in and out of the array, and put the array path to sleep and wake it again. Status-byte updates are not decided locally. When a status write byte completes with the latch set, the block raises a one-cycle request. An external protection unit answers in that same cycle with a grant, and the update is applied only if the grant is high. Two block-protect bits in the status byte select an upper region of the array that silently refuses data writes.

The FSM states are ST_IDLE (select high), ST_OPC (collect opcode), ST_AHI and ST_ALO (address high and low bytes), ST_RDAT (stream array bytes out), ST_WDAT (stream array bytes in), ST_SROUT (repeat the status byte), ST_SRIN (collect the status write byte) and ST_SKIP (ignore everything until select rises). The transitions are as follows:
- Any state moves to ST_IDLE when select goes high.
- ST_IDLE moves to ST_OPC when select goes low.
- ST_OPC moves to ST_AHI on a data read or data write opcode, to ST_SROUT on a status read, and to ST_SRIN on a status write. It moves to ST_SKIP on every other opcode, and on any opcode at all while asleep.
- ST_AHI moves to ST_ALO.
- ST_ALO moves to ST_RDAT or ST_WDAT, depending on the opcode.
- ST_SRIN moves to ST_SKIP.

Top module: `spimem_front`

## Requirements
- R1: After reset, SO output-enable is low, no RAM strobe or status request is issued, and the status byte reads 00h.
- R2: Only the first byte of a select-low window is treated as an opcode. Later bytes in the same window never start a new command. An unrecognised opcode leaves SO disabled and produces no strobes until select rises.
- R3: Opcode 06h sets the write-enable latch and 04h clears it. Opcode 05h returns the status byte on every following byte slot. The status byte is laid out as bit 7 = status lock bit, bits 3:2 = block-protect field, bit 1 = write-enable latch, and all other bits zero.
- R4: Opcode 01h takes one data byte. Its bit 7 and bits 3:2 replace the lock bit and protect field, but only when the latch is set and the protection unit grants the request in the cycle it is raised.
- R5: Opcode 02h is followed by a 16-bit address, MSB first, whose top bit is ignored. Each completed data byte is then written to the current address with no wait states, provided the latch is set.
- R6: Opcode 03h followed by the same address form streams array bytes on SO, MSB first. SO changes after falling SCK edges, and SI is taken on rising edges.
- R7: The address advances by one after every data byte in both directions, and wraps from 7FFFh to 0000h.
- R8: If select rises partway through a byte, that partial byte is discarded and is never written.
- R9: SCK idle-low (mode 0) and idle-high (mode 3) windows produce identical results, since only edges inside the window are counted.
- R10: Opcode B9h puts the block to sleep and ABh wakes it. While asleep, every other opcode is ignored, SO stays disabled and no RAM strobe is issued.
- R11: While the pause input is low, SCK edges are ignored and SO is disabled. The transfer resumes from the same bit when the input returns high.
- R12: A data write to a protected address leaves the array unchanged, but the address still advances. The protected regions are: field 01 = 6000h to 7FFFh, 10 = 4000h to 7FFFh, 11 = the whole array, 00 = none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO |
| mem_addr | output | 15 | RAM byte address |
| mem_re | output | 1 | RAM read strobe; data is expected on the next cycle |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data |
| sr_req | output | 1 | Request to update the status byte |
| sr_gnt | input | 1 | Same-cycle grant from the protection unit |

## Verification
The bench targets the places where byte framing and the address counter are easy to get wrong. These include bursts that cross 7FFFh, a header whose ignored top address bit is set, and a window that ends three bits into a data byte. A design that mishandled these would write to the wrong location or commit the truncated byte. Protection is tested with bursts that start inside a protected region and continue out of it, which shows whether a blocked byte still advances the address. Sleep, pause and a second opcode sent inside one window are all tested for side effects that appear later. A faulty design would show a latch change after wake-up, or a status byte that a refused grant should have left alone.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_STAT_WR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_MEM_WR  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_MEM_RD  = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WEN_CLR = 8'h04;
    localparam logic [BYTE_W-1:0] OP_STAT_RD = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WEN_SET = 8'h06;
    localparam logic [BYTE_W-1:0] OP_RESUME  = 8'hAB;
    localparam logic [BYTE_W-1:0] OP_NAP     = 8'hB9;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_RDAT,
        ST_WDAT, ST_SROUT, ST_SRIN, ST_SKIP
    } fsm_t;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    input  logic hold_n_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic si_s,
    output logic hold_s
);
    // packed as {hold_n, cs_n, sck, si}
    localparam logic [3:0] RST_V = 4'b1100;
    localparam int LAST = STAGES - 1;

    logic [3:0] stg [STAGES];
    logic       sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
            sck_d <= 1'b0;
        end else begin
            stg[0] <= {hold_n_i, cs_n_i, sck_i, si_i};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            sck_d <= stg[LAST][1];
        end
    end

    assign sck_rise = stg[LAST][1] & ~sck_d;
    assign sck_fall = ~stg[LAST][1] & sck_d;
    assign cs_act   = ~stg[LAST][2];
    assign si_s     = stg[LAST][0];
    assign hold_s   = stg[LAST][3];
endmodule

// File: rtl/spimem_shift.sv
module spimem_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          smp,
    input  logic          sdi,
    input  logic          drv,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          sdo
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic [DW-2:0] rx_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] tx_q;

    assign rx_byte   = {rx_q, sdi};
    assign byte_done = smp && (cnt_q == LAST_BIT);
    assign sdo       = tx_q[DW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q  <= '0;
            cnt_q <= '0;
            tx_q  <= '0;
        end else begin
            if (clr) begin
                cnt_q <= '0;
            end else if (smp) begin
                rx_q  <= rx_byte[DW-2:0];
                cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
            end
            if (drv) tx_q <= load ? load_val : {tx_q[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/spimem_prot.sv
module spimem_prot (
    input  logic [1:0] bp,
    input  logic [1:0] addr_top,
    output logic       blocked
);
    always_comb begin
        unique case (bp)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = &addr_top;
            2'b10:   blocked = addr_top[1];
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spimem_front.sv
module spimem_front
    import spimem_pkg::*;
#(
    parameter int AW          = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              sr_req,
    input  logic              sr_gnt
);
    localparam int HI_W = AW - BYTE_W;

    logic sck_rise, sck_fall, cs_act, si_s, hold_s;
    logic smp, drv, byte_done, so_bit, blocked;
    logic [BYTE_W-1:0] rx_byte, status, load_val;
    logic [AW-1:0] addr_q, hdr_addr;
    logic wel_q, srwd_q, asleep_q, rd_cmd_q, load_pend_q, src_stat_q;
    logic [1:0] bp_q;
    logic [2:0] sr_data_q;
    fsm_t state_q, state_d;

    spimem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_act(cs_act), .si_s(si_s), .hold_s(hold_s)
    );

    assign smp = sck_rise & cs_act & hold_s;
    assign drv = sck_fall & cs_act & hold_s;

    assign status   = {srwd_q, 3'b000, bp_q, wel_q, 1'b0};
    assign load_val = src_stat_q ? status : mem_rdata;
    assign hdr_addr = {addr_q[AW-1:BYTE_W], rx_byte};

    spimem_shift #(.DW(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(!cs_act), .smp(smp), .sdi(si_s),
        .drv(drv), .load(load_pend_q), .load_val(load_val),
        .byte_done(byte_done), .rx_byte(rx_byte), .sdo(so_bit)
    );

    spimem_prot u_prot (
        .bp(bp_q), .addr_top(addr_q[AW-1 -: 2]), .blocked(blocked)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cs_act) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_OPC;
                ST_OPC: if (byte_done) begin
                    if (asleep_q) state_d = ST_SKIP;
                    else begin
                        case (rx_byte)
                            OP_MEM_RD, OP_MEM_WR: state_d = ST_AHI;
                            OP_STAT_RD:           state_d = ST_SROUT;
                            OP_STAT_WR:           state_d = ST_SRIN;
                            default:              state_d = ST_SKIP;
                        endcase
                    end
                end
                ST_AHI:  if (byte_done) state_d = ST_ALO;
                ST_ALO:  if (byte_done) state_d = rd_cmd_q ? ST_RDAT : ST_WDAT;
                ST_SRIN: if (byte_done) state_d = ST_SKIP;
                default: state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pin outputs
    always_comb begin
        so_oe = cs_act & hold_s & ~asleep_q &
                ((state_q == ST_RDAT) || (state_q == ST_SROUT));
        so    = so_oe & so_bit;
    end

    // datapath, strobes and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; mem_addr <= '0; mem_wdata <= '0;
            mem_re <= 1'b0; mem_we <= 1'b0; sr_req <= 1'b0; sr_data_q <= '0;
            wel_q <= 1'b0; srwd_q <= 1'b0; bp_q <= '0; asleep_q <= 1'b0;
            rd_cmd_q <= 1'b0; load_pend_q <= 1'b0; src_stat_q <= 1'b0;
        end else begin
            mem_re <= 1'b0;
            mem_we <= 1'b0;
            sr_req <= 1'b0;
            if (sr_req && sr_gnt) begin
                srwd_q <= sr_data_q[2];
                bp_q   <= sr_data_q[1:0];
            end
            if (!cs_act || (drv && load_pend_q)) load_pend_q <= 1'b0;
            if (byte_done) begin
                case (state_q)
                    ST_OPC: if (!asleep_q || rx_byte == OP_RESUME) begin
                        case (rx_byte)
                            OP_WEN_SET: wel_q    <= 1'b1;
                            OP_WEN_CLR: wel_q    <= 1'b0;
                            OP_NAP:     asleep_q <= 1'b1;
                            OP_RESUME:  asleep_q <= 1'b0;
                            OP_MEM_RD:  rd_cmd_q <= 1'b1;
                            OP_MEM_WR:  rd_cmd_q <= 1'b0;
                            OP_STAT_RD: begin load_pend_q <= 1'b1; src_stat_q <= 1'b1; end
                            default: ;
                        endcase
                    end
                    ST_AHI: addr_q[AW-1:BYTE_W] <= rx_byte[HI_W-1:0];
                    ST_ALO: begin
                        if (rd_cmd_q) begin
                            mem_re      <= 1'b1;
                            mem_addr    <= hdr_addr;
                            addr_q      <= hdr_addr + 1'b1;
                            load_pend_q <= 1'b1;
                            src_stat_q  <= 1'b0;
                        end else begin
                            addr_q <= hdr_addr;
                        end
                    end
                    ST_RDAT: begin
                        mem_re      <= 1'b1;
                        mem_addr    <= addr_q;
                        addr_q      <= addr_q + 1'b1;
                        load_pend_q <= 1'b1;
                        src_stat_q  <= 1'b0;
                    end
                    ST_WDAT: begin
                        if (wel_q && !blocked) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= addr_q;
                            mem_wdata <= rx_byte;
                        end
                        addr_q <= addr_q + 1'b1;
                    end
                    ST_SROUT: begin load_pend_q <= 1'b1; src_stat_q <= 1'b1; end
                    ST_SRIN: begin
                        sr_req    <= wel_q;
                        sr_data_q <= {rx_byte[7], rx_byte[3:2]};
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (addr_q == mem_addr + AW'(1)));

    // R10
    nap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |-> (!so_oe && !mem_re && !mem_we));

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !hold_s && state_q != ST_IDLE) |=> $stable(state_q));

    // R8
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !mem_we);

    // R4
    sr_req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req |-> wel_q);

    // R5
    wr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel_q);
endmodule

// File: tb/spimem_front_test.sv
module spimem_front_test;
    localparam int HP = 8;
    localparam int AW = 15;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, mem_re, mem_we, sr_req;
    logic sr_allow = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    spimem_front uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sr_req(sr_req), .sr_gnt(sr_allow)
    );

    // sparse RAM model
    logic [7:0] ram [int];
    always @(posedge clk) begin
        if (mem_we) ram[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    end

    // reference model
    logic [7:0] refm [int];
    bit ref_wel = 0, ref_srwd = 0, ref_nap = 0;
    bit [1:0] ref_bp = 0;

    function automatic logic [7:0] ref_rd(int a);
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction
    function automatic bit ref_blk(int a);
        case (ref_bp)
            2'b00: return 0;
            2'b01: return a >= 32'h6000;
            2'b10: return a >= 32'h4000;
            default: return 1;
        endcase
    endfunction
    function automatic logic [7:0] ref_stat();
        return {ref_srwd, 3'b000, ref_bp, ref_wel, 1'b0};
    endfunction

    // scoreboard
    typedef struct { logic [7:0] v; string tag; } item_t;
    item_t exp_q[$];
    item_t got_q[$];
    int n_chk = 0, n_fail = 0;

    always @(negedge clk) begin
        while (exp_q.size() > 0 && got_q.size() > 0) begin
            item_t e, g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            n_chk++;
            if (g.v !== e.v) begin
                n_fail++;
                $display("FAIL %s: got %02h expected %02h", e.tag, g.v, e.v);
            end
        end
    end

    task automatic push_pair(logic [7:0] expv, logic [7:0] gotv, string tag);
        item_t e, g;
        e.v = expv; e.tag = tag; g.v = gotv; g.tag = tag;
        exp_q.push_back(e);
        got_q.push_back(g);
    endtask

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic wait_hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_lo(bit m3);
        sck = m3; wait_hp();
        cs_n = 1'b0; wait_hp();
    endtask

    task automatic cs_hi(bit m3);
        if (!m3) begin sck = 1'b0; wait_hp(); end
        cs_n = 1'b1; wait_hp(); wait_hp();
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        output logic [7:0] rx, output bit oe_seen);
        logic [7:0] r = 8'h00;
        bit oe = 0;
        for (int b = 0; b < nbits; b++) begin
            if (b == hold_at) begin
                hold_n = 1'b0; wait_hp();
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b0; wait_hp(); sck = 1'b1; wait_hp();
                end
                chk(so_oe == 1'b0, "R11 SO disabled during pause", so_oe, 0);
                hold_n = 1'b1; wait_hp();
            end
            sck = 1'b0; si = tx[7-b]; wait_hp();
            r = {r[6:0], so}; oe |= so_oe;
            sck = 1'b1; wait_hp();
        end
        rx = r; oe_seen = oe;
    endtask

    task automatic op_only(logic [7:0] op, bit m3);
        logic [7:0] r; bit oe;
        cs_lo(m3); xfer(op, 8, -1, r, oe); cs_hi(m3);
        if (ref_nap) begin
            if (op == 8'hAB) ref_nap = 0;
        end else begin
            case (op)
                8'h06: ref_wel = 1;
                8'h04: ref_wel = 0;
                8'hB9: ref_nap = 1;
                8'hAB: ref_nap = 0;
                default: ;
            endcase
        end
    endtask

    task automatic rd_stat(int n, bit m3, string tag);
        logic [7:0] r; bit oe;
        cs_lo(m3); xfer(8'h05, 8, -1, r, oe);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, -1, r, oe);
            if (ref_nap) chk(!oe, tag, oe, 0);
            else push_pair(ref_stat(), r, tag);
        end
        cs_hi(m3);
    endtask

    task automatic wr_stat(logic [7:0] val, bit allow, bit m3);
        logic [7:0] r; bit oe;
        sr_allow = allow;
        cs_lo(m3); xfer(8'h01, 8, -1, r, oe); xfer(val, 8, -1, r, oe); cs_hi(m3);
        if (!ref_nap && ref_wel && allow) begin
            ref_srwd = val[7]; ref_bp = val[3:2];
        end
    endtask

    task automatic mem_wr(int a, int n, logic [7:0] d0, bit m3, int tail_bits);
        logic [7:0] r; bit oe;
        int cur = a & 32'h7FFF;
        cs_lo(m3);
        xfer(8'h02, 8, -1, r, oe); xfer(a[15:8], 8, -1, r, oe); xfer(a[7:0], 8, -1, r, oe);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = d0 + 8'(i * 7);
            xfer(d, 8, -1, r, oe);
            if (!ref_nap && ref_wel && !ref_blk(cur)) refm[cur] = d;
            cur = (cur + 1) & 32'h7FFF;
        end
        if (tail_bits > 0) xfer(8'hEE, tail_bits, -1, r, oe);
        cs_hi(m3);
    endtask

    task automatic mem_rd(int a, int n, bit m3, int hold_byte, string tag);
        logic [7:0] r; bit oe;
        int cur = a & 32'h7FFF;
        cs_lo(m3);
        xfer(8'h03, 8, -1, r, oe); xfer(a[15:8], 8, -1, r, oe); xfer(a[7:0], 8, -1, r, oe);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, (i == hold_byte) ? 4 : -1, r, oe);
            if (ref_nap) chk(!oe, tag, oe, 0);
            else push_pair(ref_rd(cur), r, tag);
            cur = (cur + 1) & 32'h7FFF;
        end
        cs_hi(m3);
    endtask

    bit finished = 0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r; bit oe, oe2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk(so_oe == 1'b0, "R1 so_oe after reset", so_oe, 0);
        chk(!mem_re && !mem_we && !sr_req, "R1 no strobes after reset",
            {mem_re, mem_we, sr_req}, 0);
        rd_stat(2, 0, "R1 status after reset");

        // R5 write without latch has no effect
        mem_wr(32'h0010, 2, 8'h5A, 0, 0);
        op_only(8'h06, 0);
        rd_stat(1, 1, "R3 latch set by 06h");
        mem_rd(32'h0010, 2, 0, -1, "R5 write refused without latch");

        // R5 R6 R9 bursts in both modes
        mem_wr(32'h0100, 4, 8'h11, 0, 0);
        mem_rd(32'h0100, 4, 1, -1, "R9 mode3 read of mode0 write");
        mem_wr(32'h0180, 3, 8'hC3, 1, 0);
        mem_rd(32'h0180, 3, 0, -1, "R6 mode0 read of mode3 write");

        // R5 top header bit ignored
        mem_wr(32'h8200, 1, 8'h77, 0, 0);
        mem_rd(32'h0200, 1, 1, -1, "R5 top address bit ignored");

        // R7 wrap both directions
        mem_wr(32'h7FFF, 3, 8'hA0, 0, 0);
        mem_rd(32'h7FFE, 4, 0, -1, "R7 wrap 7FFFh to 0000h");

        // R8 partial byte discarded
        mem_wr(32'h0300, 2, 8'h31, 1, 3);
        mem_rd(32'h0300, 3, 0, -1, "R8 partial byte not written");

        // R2 unknown opcode keeps SO off
        cs_lo(0);
        xfer(8'h77, 8, -1, r, oe); xfer(8'h00, 8, -1, r, oe);
        xfer(8'h00, 8, -1, r, oe2);
        cs_hi(0);
        chk(!oe && !oe2, "R2 unknown opcode leaves SO disabled", oe | oe2, 0);

        // R2 second byte is not an opcode
        op_only(8'h04, 1);
        cs_lo(0);
        xfer(8'h05, 8, -1, r, oe); xfer(8'h06, 8, -1, r, oe);
        cs_hi(0);
        push_pair(ref_stat(), r, "R3 status read with latch clear");
        rd_stat(1, 0, "R2 06h inside window not executed");

        // R4 grant gating
        op_only(8'h06, 0);
        wr_stat(8'h8C, 0, 0);
        rd_stat(1, 0, "R4 refused grant keeps status");
        wr_stat(8'h8C, 1, 1);
        rd_stat(2, 1, "R4 granted status update");

        // R12 protection regions
        mem_wr(32'h0400, 2, 8'h44, 0, 0);
        mem_rd(32'h0400, 2, 0, -1, "R12 whole array protected");
        wr_stat(8'h04, 1, 0);
        mem_wr(32'h7FFF, 2, 8'h90, 0, 0);
        mem_rd(32'h7FFF, 2, 1, -1, "R12 upper quarter blocked, address advances");
        wr_stat(8'h08, 1, 0);
        mem_wr(32'h3FFF, 2, 8'h62, 1, 0);
        mem_rd(32'h3FFF, 2, 0, -1, "R12 upper half blocked");
        wr_stat(8'h00, 1, 0);
        rd_stat(1, 0, "R4 protect cleared");

        // R10 sleep and wake
        op_only(8'hB9, 0);
        rd_stat(1, 0, "R10 status read ignored while asleep");
        op_only(8'h04, 1);
        mem_wr(32'h0100, 2, 8'hFF, 0, 0);
        mem_rd(32'h0100, 1, 0, -1, "R10 read ignored while asleep");
        op_only(8'hAB, 0);
        rd_stat(1, 0, "R10 latch kept across sleep");
        mem_rd(32'h0100, 2, 1, -1, "R10 array untouched while asleep");

        // R11 pause in the middle of read bytes
        mem_rd(32'h0100, 3, 0, 1, "R11 read resumes after pause");
        mem_rd(32'h0180, 2, 1, 0, "R11 mode3 pause");

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0 && got_q.size() == 0, "R6 scoreboard drained",
            exp_q.size() + got_q.size(), 0);
        finish_run();
    end
endmodule